// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a display controller's memory fetch path and its colour pipeline. It accepts 32-bit framebuffer words over a valid/ready handshake, keeps each word until every pixel packed inside it has been handed on, and emits one pixel per accepted output transfer. For indexed depths the pixel appears as an 8-bit palette index. For direct-colour depths it appears as three 8-bit channels. Memory fetch and palette lookup belong to neighbouring blocks.

Pixel order within a word is chosen by two endian controls. The byte-endian control wins when both are set. A BGR control swaps the outer colour channels. The parameter `EXTENDED` selects between two variants. The base variant has only one 16-bit depth code, and an external two-bit mux input picks its layout. The extended variant has separate depth codes for its 16-bit and 12-bit layouts and ignores the mux input. The block also reports, combinationally, how many bytes one display line occupies at the selected depth.

The configuration inputs are assumed to be static while pixels are pending. They change only when the block is idle.

Top module: `fb_unpack`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A word is taken when `in_valid` and `in_ready` are both high, and it is held until all of its 32/bpp pixels have been transferred. During a stall (`out_valid` high, `out_ready` low) the pixel outputs stay stable and `in_ready` is 0. After the last pixel of the last word, `out_valid` drops.
- R3: Depth codes 0, 1, 2 and 3 select indexed pixels of 1, 2, 4 and 8 bits. The field is zero-extended onto `out_index`, `out_direct` is 0, and the colour outputs are 0.
- R4: With both endian controls clear, pixel i of a word is the field at bit offset i*bpp, so the first pixel comes from the least significant bits.
- R5: With only the pixel-endian control set and bpp below 8, bytes are taken from the lowest byte upward, and within each byte the most significant pixel comes first. At 8 bpp and above, this mode orders pixels as R4 does.
- R6: With the byte-endian control set, pixel i is the field at bit offset 32-(i+1)*bpp, whatever the pixel-endian control says.
- R7: The 5551 layout takes channel A from bits [4:0], green from [9:5] and channel C from [14:10], and ignores bit 15. Every 5-bit channel is widened to 8 bits by a left shift of 3 with zero fill.
- R8: Code 5 is 32 bpp: channel A from bits [7:0], green from [15:8], channel C from [23:16], bits [31:24] ignored. On the extended variant, code 6 is 565 (A [4:0], green [10:5] shifted left 2, C [15:11]) and code 7 is 444 in a 16-bit container (A [3:0], green [7:4], C [11:8], each shifted left 4). `out_index` is 0 in every direct mode.
- R9: Channel A drives red and channel C drives blue when the BGR control is 0. They are exchanged when it is 1, unless R10 fixes the order.
- R10: On the base variant at code 4, mux value 1 selects 5551. Mux value 3 selects 565 with channel A fixed on blue. Mux values 0 and 2 select 565 with the order set by the BGR control.
- R11: On the extended variant, code 4 is always 5551 and the mux input has no effect.
- R12: On the base variant, codes 6 and 7 behave exactly as code 4.
- R13: `line_bytes` equals width/8, width/4 and width/2 for codes 0, 1 and 2; width for code 3; width*2 for codes 4, 6 and 7; and width*4 for code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_depth | input | 3 | Depth code |
| cfg_bgr | input | 1 | Exchange the outer colour channels |
| cfg_byte_be | input | 1 | Big-endian byte ordering (takes priority) |
| cfg_pix_be | input | 1 | Big-endian pixel ordering within bytes |
| fmt_mux | input | 2 | External 16-bit layout select (base variant) |
| line_width | input | WIDTH_W | Display line width in pixels |
| line_bytes | output | WIDTH_W+2 | Bytes per display line |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Framebuffer word |
| in_ready | output | 1 | Block can take a word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_direct | output | 1 | 1 for direct colour, 0 for an index |
| out_index | output | 8 | Palette index |
| out_r | output | 8 | Red channel |
| out_g | output | 8 | Green channel |
| out_b | output | 8 | Blue channel |

## Verification
The bench instantiates both variants side by side on the same inputs. It sweeps every depth code, both BGR settings, all four endian combinations and all four mux values. Each sweep point gets a fixed pattern word followed by random words. The pattern words (ascending nibbles, single end bits, all ones, all zeros) separate slot reversal from in-byte reversal and make a dropped or misplaced channel bit visible. Random words catch field masking and bit-15 or top-byte leakage. Random stalls on the output side exercise word holding, pixel counting and back-to-back word hand-over.

// File: rtl/fbu_pkg.sv
// Shared types and sizes for the framebuffer unpacker.
// Assumes a 32-bit framebuffer word and 8-bit colour channels.
package fbu_pkg;
    localparam int WORD_W = 32;
    localparam int CH_W   = 8;
    localparam int FLD_W  = 24;   // widest field any format decodes
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int LG_W   = 3;

    typedef enum logic [2:0] {
        FMT_INDEX = 3'd0,
        FMT_5551  = 3'd1,
        FMT_565   = 3'd2,
        FMT_444   = 3'd3,
        FMT_888   = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [LG_W-1:0] lg;    // log2 of bits per pixel
        fmt_e            fmt;
        logic            swap;  // channel A goes to blue
    } mode_t;
endpackage

// File: rtl/fbu_mode_dec.sv
// Decodes depth code, BGR control and external mux into pixel size,
// layout and channel order. EXTENDED picks the variant at elaboration.
module fbu_mode_dec
    import fbu_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic [2:0] depth,
    input  logic       bgr,
    input  logic [1:0] mux,
    output mode_t      mode
);
    generate
        if (EXTENDED) begin : g_ext
            // Extended variant: layout comes from the depth code alone.
            always_comb begin
                mode.swap = bgr;
                mode.lg   = 3'd4;
                mode.fmt  = FMT_5551;
                case (depth)
                    3'd0, 3'd1, 3'd2, 3'd3: begin
                        mode.lg   = depth;
                        mode.fmt  = FMT_INDEX;
                        mode.swap = 1'b0;
                    end
                    3'd5:    begin mode.lg = 3'd5; mode.fmt = FMT_888; end
                    3'd6:    mode.fmt = FMT_565;
                    3'd7:    mode.fmt = FMT_444;
                    default: mode.fmt = FMT_5551;
                endcase
            end
        end else begin : g_base
            // Base variant: the 16-bit layout comes from the external mux.
            always_comb begin
                mode.swap = bgr;
                mode.lg   = 3'd4;
                mode.fmt  = FMT_565;
                case (depth)
                    3'd0, 3'd1, 3'd2, 3'd3: begin
                        mode.lg   = depth;
                        mode.fmt  = FMT_INDEX;
                        mode.swap = 1'b0;
                    end
                    3'd5: begin mode.lg = 3'd5; mode.fmt = FMT_888; end
                    default: begin
                        case (mux)
                            2'd1:    mode.fmt = FMT_5551;
                            2'd3:    mode.swap = 1'b1;
                            default: mode.fmt = FMT_565;
                        endcase
                    end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/fbu_word_buf.sv
// Holds one framebuffer word and the index of the next pixel to emit.
// Assumes last_idx stays constant while a word is held.
module fbu_word_buf
    import fbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    input  logic [CNT_W-1:0]  last_idx,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  idx
);
    logic full;
    logic at_last;

    assign at_last   = (idx == last_idx);
    assign out_valid = full;
    assign in_ready  = !full || (out_ready && at_last);

    // Load a new word, step through its pixels, release it after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            idx  <= '0;
            word <= '0;
        end else if (in_valid && in_ready) begin
            word <= in_data;
            full <= 1'b1;
            idx  <= '0;
        end else if (full && out_ready) begin
            if (at_last) full <= 1'b0;
            else         idx  <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/fbu_pix_sel.sv
// Maps the emission index onto a slot in the word and extracts the field.
// Byte-endian ordering takes priority over pixel-endian ordering.
module fbu_pix_sel
    import fbu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  idx,
    input  logic [LG_W-1:0]   lg,
    input  logic              byte_be,
    input  logic              pix_be,
    output logic [CNT_W-1:0]  last_idx,
    output logic [FLD_W-1:0]  field
);
    logic [CNT_W:0]     pcount;
    logic [CNT_W-1:0]   in_byte_m1;
    logic [CNT_W-1:0]   slot;
    logic [2*CNT_W-1:0] sh_wide;
    logic [CNT_W-1:0]   shamt;
    logic [CNT_W:0]     bpp;
    logic [FLD_W-1:0]   mask;

    // Pixel count, the in-byte reversal mask and the slot for this index.
    always_comb begin
        pcount     = (CNT_W+1)'(WORD_W) >> lg;
        last_idx   = CNT_W'(pcount - 1'b1);
        in_byte_m1 = (lg < 3'd3) ? CNT_W'((4'd8 >> lg) - 4'd1) : '0;
        if (byte_be)     slot = last_idx - idx;
        else if (pix_be) slot = idx ^ in_byte_m1;
        else             slot = idx;
    end

    // Shift the chosen slot down and mask it to the pixel width.
    always_comb begin
        sh_wide = {{CNT_W{1'b0}}, slot} << lg;
        shamt   = sh_wide[CNT_W-1:0];
        bpp     = (CNT_W+1)'(1) << lg;
        mask    = FLD_W'((33'd1 << bpp) - 33'd1);
        field   = FLD_W'(word >> shamt) & mask;
    end
endmodule

// File: rtl/fbu_color.sv
// Turns an extracted field into an index or three widened colour channels.
// Narrow channels are widened by a left shift with zeros below.
module fbu_color
    import fbu_pkg::*;
(
    input  logic [FLD_W-1:0] field,
    input  fmt_e             fmt,
    input  logic             swap,
    output logic             direct,
    output logic [CH_W-1:0]  index,
    output logic [CH_W-1:0]  r,
    output logic [CH_W-1:0]  g,
    output logic [CH_W-1:0]  b
);
    logic [CH_W-1:0] ch_a;
    logic [CH_W-1:0] ch_c;

    // Unpack the channels for the active layout.
    always_comb begin
        direct = 1'b1;
        index  = '0;
        ch_a   = '0;
        g      = '0;
        ch_c   = '0;
        case (fmt)
            FMT_5551: begin
                ch_a = {field[4:0],   3'b0};
                g    = {field[9:5],   3'b0};
                ch_c = {field[14:10], 3'b0};
            end
            FMT_565: begin
                ch_a = {field[4:0],   3'b0};
                g    = {field[10:5],  2'b0};
                ch_c = {field[15:11], 3'b0};
            end
            FMT_444: begin
                ch_a = {field[3:0],  4'b0};
                g    = {field[7:4],  4'b0};
                ch_c = {field[11:8], 4'b0};
            end
            FMT_888: begin
                ch_a = field[7:0];
                g    = field[15:8];
                ch_c = field[23:16];
            end
            default: begin
                direct = 1'b0;
                index  = field[7:0];
            end
        endcase
    end

    // Place the outer channels according to the swap control.
    always_comb begin
        r = swap ? ch_c : ch_a;
        b = swap ? ch_a : ch_c;
    end
endmodule

// File: rtl/fb_unpack.sv
// Framebuffer word to pixel unpacker, top level. The configuration
// inputs must not change while out_valid is high.
module fb_unpack
    import fbu_pkg::*;
#(
    parameter bit EXTENDED = 1'b0,
    parameter int WIDTH_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_depth,
    input  logic               cfg_bgr,
    input  logic               cfg_byte_be,
    input  logic               cfg_pix_be,
    input  logic [1:0]         fmt_mux,
    input  logic [WIDTH_W-1:0] line_width,
    output logic [WIDTH_W+1:0] line_bytes,
    input  logic               in_valid,
    input  logic [31:0]        in_data,
    output logic               in_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_direct,
    output logic [7:0]         out_index,
    output logic [7:0]         out_r,
    output logic [7:0]         out_g,
    output logic [7:0]         out_b
);
    localparam int LB_W = WIDTH_W + 2;

    mode_t              mode;
    logic [WORD_W-1:0]  word;
    logic [CNT_W-1:0]   idx;
    logic [CNT_W-1:0]   last_idx;
    logic [FLD_W-1:0]   field;
    logic [LB_W-1:0]    wext;

    fbu_mode_dec #(.EXTENDED(EXTENDED)) u_dec (
        .depth (cfg_depth),
        .bgr   (cfg_bgr),
        .mux   (fmt_mux),
        .mode  (mode)
    );

    fbu_word_buf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .last_idx  (last_idx),
        .word      (word),
        .idx       (idx)
    );

    fbu_pix_sel u_sel (
        .word     (word),
        .idx      (idx),
        .lg       (mode.lg),
        .byte_be  (cfg_byte_be),
        .pix_be   (cfg_pix_be),
        .last_idx (last_idx),
        .field    (field)
    );

    fbu_color u_col (
        .field  (field),
        .fmt    (mode.fmt),
        .swap   (mode.swap),
        .direct (out_direct),
        .index  (out_index),
        .r      (out_r),
        .g      (out_g),
        .b      (out_b)
    );

    // Bytes per display line for the selected depth code.
    always_comb begin
        wext = LB_W'(line_width);
        case (cfg_depth)
            3'd0:    line_bytes = wext >> 3;
            3'd1:    line_bytes = wext >> 2;
            3'd2:    line_bytes = wext >> 1;
            3'd3:    line_bytes = wext;
            3'd5:    line_bytes = wext << 2;
            default: line_bytes = wext << 1;
        endcase
    end
endmodule

// File: rtl/fbu_unpack_chk.sv
// Property checker for fb_unpack, attached to every instance with bind.
module fbu_unpack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_depth,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_direct,
    input logic [7:0] out_index,
    input logic [7:0] out_r,
    input logic [7:0] out_g,
    input logic [7:0] out_b
);
    AST_HOLD_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_index) && $stable(out_r)
            && $stable(out_g) && $stable(out_b) && $stable(out_direct)); // R2

    AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && out_valid |-> out_ready); // R2

    AST_INDEX_NO_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_direct |-> (out_r == 8'd0) && (out_g == 8'd0) && (out_b == 8'd0)); // R3

    AST_INDEXED_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (cfg_depth <= 3'd3) |-> !out_direct); // R3

    AST_DIRECT_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_direct |-> out_index == 8'd0); // R8

    AST_WIDEN_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_direct && (cfg_depth != 3'd5) |->
            (out_r[2:0] == 3'd0) && (out_b[2:0] == 3'd0)); // R7
endmodule

bind fb_unpack fbu_unpack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_depth  (cfg_depth),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_direct (out_direct),
    .out_index  (out_index),
    .out_r      (out_r),
    .out_g      (out_g),
    .out_b      (out_b)
);

// File: tb/fb_unpack_bench.sv
`timescale 1ns/1ps
module fb_unpack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_depth = 3'd0;
    logic        cfg_bgr = 1'b0;
    logic        cfg_byte_be = 1'b0;
    logic        cfg_pix_be = 1'b0;
    logic [1:0]  fmt_mux = 2'd0;
    logic [11:0] line_width = 12'd0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = 32'd0;
    logic        out_ready = 1'b0;

    logic [13:0] b_lb, e_lb;
    logic        b_in_ready, e_in_ready, b_out_valid, e_out_valid, b_direct, e_direct;
    logic [7:0]  b_idx, e_idx, b_r, e_r, b_g, e_g, b_b, e_b;

    int checks = 0;
    int errors = 0;
    logic [31:0] stream [4];

    always #2.5 clk = ~clk;

    fb_unpack #(.EXTENDED(1'b0), .WIDTH_W(12)) u_fb_unpack (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
        .cfg_byte_be(cfg_byte_be), .cfg_pix_be(cfg_pix_be), .fmt_mux(fmt_mux),
        .line_width(line_width), .line_bytes(b_lb), .in_valid(in_valid),
        .in_data(in_data), .in_ready(b_in_ready), .out_valid(b_out_valid),
        .out_ready(out_ready), .out_direct(b_direct), .out_index(b_idx),
        .out_r(b_r), .out_g(b_g), .out_b(b_b));

    fb_unpack #(.EXTENDED(1'b1), .WIDTH_W(12)) u_fb_unpack_ext (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
        .cfg_byte_be(cfg_byte_be), .cfg_pix_be(cfg_pix_be), .fmt_mux(fmt_mux),
        .line_width(line_width), .line_bytes(e_lb), .in_valid(in_valid),
        .in_data(in_data), .in_ready(e_in_ready), .out_valid(e_out_valid),
        .out_ready(out_ready), .out_direct(e_direct), .out_index(e_idx),
        .out_r(e_r), .out_g(e_g), .out_b(e_b));

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int bits_per_pixel(input logic [2:0] depth);
        int d = int'(depth);
        if (d <= 3) return 1 << d;
        if (d == 5) return 32;
        return 16;
    endfunction

    // Expected pixel: {direct, index, r, g, b}
    function automatic logic [32:0] model(input bit ext, input logic [2:0] depth,
            input bit bgr, input bit bbe, input bit pbe, input logic [1:0] mux,
            input logic [31:0] w, input int i);
        int d = int'(depth);
        int bpp, pos, kind;
        bit sw = bgr;
        logic [31:0] f;
        logic [7:0] c0, gg, c2, r, b;
        if (!ext && d >= 6) d = 4;
        kind = 0;
        if (d <= 3) bpp = 1 << d;
        else if (d == 5) begin bpp = 32; kind = 4; end
        else begin
            bpp = 16;
            if (d == 6) kind = 2;
            else if (d == 7) kind = 3;
            else if (ext || mux == 2'd1) kind = 1;
            else begin kind = 2; if (mux == 2'd3) sw = 1'b1; end
        end
        if (bbe) pos = 32 - (i + 1) * bpp;
        else if (pbe && bpp < 8) pos = ((i * bpp) / 8) * 8 + 8 - ((i * bpp) % 8) - bpp;
        else pos = i * bpp;
        f = 32'((64'(w) >> pos) & ((64'd1 << bpp) - 64'd1));
        c0 = 8'd0; gg = 8'd0; c2 = 8'd0;
        case (kind)
            1: begin c0 = {f[4:0], 3'b0}; gg = {f[9:5], 3'b0};  c2 = {f[14:10], 3'b0}; end
            2: begin c0 = {f[4:0], 3'b0}; gg = {f[10:5], 2'b0}; c2 = {f[15:11], 3'b0}; end
            3: begin c0 = {f[3:0], 4'b0}; gg = {f[7:4], 4'b0};  c2 = {f[11:8], 4'b0}; end
            4: begin c0 = f[7:0]; gg = f[15:8]; c2 = f[23:16]; end
            default: ;
        endcase
        if (kind == 0) return {1'b0, f[7:0], 24'd0};
        r = sw ? c2 : c0;
        b = sw ? c0 : c2;
        return {1'b1, 8'd0, r, gg, b};
    endfunction

    function automatic string tag_of(input bit ext);
        string t;
        int d = int'(cfg_depth);
        if (cfg_byte_be) t = "R6";
        else if (cfg_pix_be) t = "R5";
        else t = "R4";
        if (d <= 3) t = {t, " R3"};
        else if (!ext && d >= 6) t = {t, " R12 R10 R9"};
        else if (d == 4) t = ext ? {t, " R11 R7 R9"} : {t, " R10 R9"};
        else t = {t, " R8 R9"};
        return t;
    endfunction

    function automatic logic [13:0] exp_lb(input logic [2:0] depth, input logic [11:0] w);
        logic [13:0] x = {2'b00, w};
        case (depth)
            3'd0: return x >> 3;
            3'd1: return x >> 2;
            3'd2: return x >> 1;
            3'd3: return x;
            3'd5: return x << 2;
            default: return x << 1;
        endcase
    endfunction

    task automatic produce(input int nwords);
        for (int k = 0; k < nwords; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = stream[k];
            #1;
            while (!b_in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic consume(input int nwords);
        int k = 0;
        int i = 0;
        int np = 32 / bits_per_pixel(cfg_depth);
        logic [32:0] eb, ee, ab, ae;
        while (k < nwords) begin
            @(negedge clk);
            out_ready = ($urandom_range(0, 3) != 0);
            #1;
            if (!(b_out_valid && e_out_valid)) continue;
            eb = model(1'b0, cfg_depth, cfg_bgr, cfg_byte_be, cfg_pix_be, fmt_mux, stream[k], i);
            ee = model(1'b1, cfg_depth, cfg_bgr, cfg_byte_be, cfg_pix_be, fmt_mux, stream[k], i);
            ab = {b_direct, b_idx, b_r, b_g, b_b};
            ae = {e_direct, e_idx, e_r, e_g, e_b};
            chk(ab === eb, tag_of(1'b0), "base pixel", ab, eb);
            chk(ae === ee, tag_of(1'b1), "ext pixel", ae, ee);
            if (!out_ready) begin
                chk(!b_in_ready && !e_in_ready, "R2", "in_ready during stall",
                    {31'd0, b_in_ready, e_in_ready}, 33'd0);
            end else begin
                i++;
                if (i == np) begin i = 0; k++; end
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk(!b_out_valid && !e_out_valid, "R2", "out_valid after last pixel",
            {31'd0, b_out_valid, e_out_valid}, 33'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int combo = 0;
        logic [31:0] pat [4];
        void'($urandom(32'd20240611));
        pat[0] = 32'h0123_4567; pat[1] = 32'h8000_0001;
        pat[2] = 32'hFFFF_FFFF; pat[3] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        #1;
        chk(!b_out_valid && b_in_ready && !e_out_valid && e_in_ready, "R1", "in reset",
            {29'd0, b_out_valid, b_in_ready, e_out_valid, e_in_ready}, 33'h5);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!b_out_valid && b_in_ready && !e_out_valid && e_in_ready, "R1", "after reset",
            {29'd0, b_out_valid, b_in_ready, e_out_valid, e_in_ready}, 33'h5);

        for (int d = 0; d < 8; d++) begin
            for (int c = 0; c < 2; c++) begin
                for (int en = 0; en < 4; en++) begin
                    for (int m = 0; m < 4; m++) begin
                        @(negedge clk);
                        cfg_depth   = 3'(d);
                        cfg_bgr     = (c != 0);
                        cfg_byte_be = (en >= 2);
                        cfg_pix_be  = (en % 2 == 1);
                        fmt_mux     = 2'(m);
                        line_width  = 12'($urandom_range(0, 4095));
                        #1;
                        chk(b_lb === exp_lb(cfg_depth, line_width) && e_lb === exp_lb(cfg_depth, line_width),
                            "R13", "line bytes", {19'd0, b_lb}, {19'd0, exp_lb(cfg_depth, line_width)});
                        stream[0] = pat[combo % 4];
                        for (int k = 1; k < 4; k++) stream[k] = $urandom();
                        combo++;
                        fork
                            produce(4);
                            consume(4);
                        join
                    end
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule